// File: doc/BRIEF.md
# Regulator power-mode controller

This block decides when the primary supply regulator runs, when it is parked in standby, and when an active clamp pulls the regulated supply to ground. It uses three fields of a latched configuration byte: a regulator-enable option, a clamp option and a bus-wake option. It also takes a battery-adequate flag, a one-cycle software write strobe that carries a power-down control bit, and two asynchronous wake lines, ignition and bus.

The controller has three states: off, run and standby. It leaves reset in off. The first qualifying wake edge seen while the battery is adequate moves it to run. Software enters standby by writing 0 to the power-down bit. Only a hardware wake edge brings it back to run. A status output tells software whether the primary regulator is in standby. The secondary regulator enable depends on the battery flag alone.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, `pri_en`, `clamp_en` and `stby_stat` are all 0 and the controller is off.
- R2: While `opt_byte[6]` (regulator enable) is 0, `pri_en`, `clamp_en` and `stby_stat` stay 0, whatever the wake edges and writes.
- R3: `sec_en` equals `batt_ok` at all times, whatever `opt_byte` holds.
- R4: From off, with `opt_byte[6]`=1 and `batt_ok`=1, a 0-to-1 change on `ign_in` sets `pri_en` to 1 on the third rising clock edge after the change is first sampled. `pri_en` stays 0 if the battery flag is low when the edge is seen.
- R5: In run, a write (`wr_en`=1) with `wr_pdc`=0 enters standby at that clock edge: `pri_en` becomes 0 and `stby_stat` becomes 1. A write with `wr_pdc`=1 has no effect.
- R6: When `opt_byte[5]`=1, `clamp_en` is 1 exactly while the controller is in standby. When `opt_byte[5]`=0, `clamp_en` is never 1.
- R7: In standby, a rising edge on `ign_in` returns the controller to run: `pri_en`=1, `clamp_en`=0 and `stby_stat`=0.
- R8: A rising edge on `bus_in` wakes the controller the same way as `ign_in`, but only when `opt_byte[4]`=1. When `opt_byte[4]`=0, a bus edge leaves standby unchanged.
- R9: When `batt_ok` is 0 at a clock edge, the controller goes to off from any state. The next wake edge is then needed to run again.
- R10: Wake is edge-triggered. A wake line held high wakes the controller once only, and a later entry to standby holds while that line stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opt_byte | input | 8 | Latched option byte; bit 6 regulator enable, bit 5 clamp enable, bit 4 bus wake |
| wr_en | input | 1 | One-cycle strobe for a write to the power-down control bit |
| wr_pdc | input | 1 | Value written to the power-down control bit |
| batt_ok | input | 1 | Battery voltage is adequate |
| ign_in | input | 1 | Asynchronous ignition wake line |
| bus_in | input | 1 | Asynchronous bus wake line |
| pri_en | output | 1 | Primary regulator enable |
| sec_en | output | 1 | Secondary regulator enable |
| clamp_en | output | 1 | Supply-to-ground clamp enable |
| stby_stat | output | 1 | Status: 1 while the primary regulator is in standby |

## Verification
The wake logic is tried with an ignition edge, a bus edge with the bus option set and then cleared, and a wake line held high across a second standby entry. Together these separate edge detection from level detection and show how the bus option gates the bus source. Standby is entered with the clamp option on and off, which shows that the clamp follows the option and the state together. Writes of 1 and 0, battery drops in run and in standby, and a cleared regulator option show which inputs can override the state machine.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int OPT_W          = 8;
   localparam int OPT_REGEN_BIT  = 6;
   localparam int OPT_CLAMP_BIT  = 5;
   localparam int OPT_BUSWK_BIT  = 4;

   typedef enum logic [1:0] {
      PM_OFF  = 2'd0,
      PM_RUN  = 2'd1,
      PM_STBY = 2'd2
   } pm_state_t;
endpackage

// File: rtl/pmc_wake_sync.sv
module pmc_wake_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pmc_wake_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~prev_q;

   // R10
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
   import pmc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic regen,
   input  logic clamp_opt,
   input  logic batt_ok,
   input  logic wake,
   input  logic wr_en,
   input  logic wr_pdc,
   output logic pri_en,
   output logic clamp_en,
   output logic stby_stat
);
   pm_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (!regen || !batt_ok) begin
         state_d = PM_OFF;
      end else begin
         case (state_q)
            PM_OFF:  if (wake) state_d = PM_RUN;
            PM_RUN:  if (wr_en && !wr_pdc) state_d = PM_STBY;
            PM_STBY: if (wake) state_d = PM_RUN;
            default: state_d = PM_OFF;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= PM_OFF;
      else        state_q <= state_d;
   end

   assign pri_en    = (state_q == PM_RUN);
   assign stby_stat = (state_q == PM_STBY);
   assign clamp_en  = (state_q == PM_STBY) && clamp_opt;

   // R2
   regen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !regen |=> (!pri_en && !stby_stat));
   // R5
   pdc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_en && regen && batt_ok && wr_en && !wr_pdc) |=> stby_stat);
   // R6
   clamp_only_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clamp_en |-> (stby_stat && clamp_opt));
   // R7
   stby_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stby_stat && wake && regen && batt_ok) |=> (pri_en && !clamp_en));
   // R9
   batt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !batt_ok |=> (!pri_en && !stby_stat && !clamp_en));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPT_W-1:0] opt_byte,
   input  logic             wr_en,
   input  logic             wr_pdc,
   input  logic             batt_ok,
   input  logic             ign_in,
   input  logic             bus_in,
   output logic             pri_en,
   output logic             sec_en,
   output logic             clamp_en,
   output logic             stby_stat
);
   logic ign_rise, bus_rise, wake;
   logic unused_opt;

   assign unused_opt = ^{opt_byte[7], opt_byte[3:0]};

   pmc_wake_sync #(.STAGES(SYNC_STAGES)) i_ign_sync (
      .clk(clk), .rst_n(rst_n), .async_in(ign_in), .rise(ign_rise));

   pmc_wake_sync #(.STAGES(SYNC_STAGES)) i_bus_sync (
      .clk(clk), .rst_n(rst_n), .async_in(bus_in), .rise(bus_rise));

   assign wake = ign_rise | (bus_rise & opt_byte[OPT_BUSWK_BIT]);

   pmc_fsm i_fsm (
      .clk(clk), .rst_n(rst_n),
      .regen(opt_byte[OPT_REGEN_BIT]),
      .clamp_opt(opt_byte[OPT_CLAMP_BIT]),
      .batt_ok(batt_ok), .wake(wake),
      .wr_en(wr_en), .wr_pdc(wr_pdc),
      .pri_en(pri_en), .clamp_en(clamp_en), .stby_stat(stby_stat));

   assign sec_en = batt_ok;

   // R3
   sec_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_en == batt_ok);
   // R8
   bus_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stby_stat && bus_rise && !ign_rise && !opt_byte[OPT_BUSWK_BIT]
       && !wr_en && batt_ok && opt_byte[OPT_REGEN_BIT]) |=> stby_stat);
endmodule

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] opt_byte = 8'h70;
   logic       wr_en = 1'b0, wr_pdc = 1'b1, batt_ok = 1'b0;
   logic       ign_in = 1'b0, bus_in = 1'b0;
   logic       pri_en, sec_en, clamp_en, stby_stat;
   int         total = 0, bad = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   pwr_mode_ctrl i_pwr_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .opt_byte(opt_byte), .wr_en(wr_en),
      .wr_pdc(wr_pdc), .batt_ok(batt_ok), .ign_in(ign_in), .bus_in(bus_in),
      .pri_en(pri_en), .sec_en(sec_en), .clamp_en(clamp_en),
      .stby_stat(stby_stat));

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: {pri,sec,clamp,stat} actual=%b expected=%b", req, act, exp);
      end
   endtask

   function automatic logic [3:0] outs();
      return {pri_en, sec_en, clamp_en, stby_stat};
   endfunction

   task automatic write_pdc(input logic v);
      wr_en = 1'b1; wr_pdc = v;
      tick(1);
      wr_en = 1'b0; wr_pdc = 1'b1;
   endtask

   task automatic ign_pulse();
      ign_in = 1'b1; tick(5);
      ign_in = 1'b0; tick(4);
   endtask

   task automatic t_reset();
      tick(3);
      chk("R1", {pri_en, clamp_en, stby_stat}, 3'b000);
      rst_n = 1'b1; tick(2);
      chk("R1", outs(), 4'b0000);
   endtask

   task automatic t_secondary();
      opt_byte = 8'h00; batt_ok = 1'b1; #1;
      chk("R3", {3'b000, sec_en}, 4'b0001);
      opt_byte = 8'h70; batt_ok = 1'b0; #1;
      chk("R3", {3'b000, sec_en}, 4'b0000);
   endtask

   task automatic t_off_wake();
      batt_ok = 1'b0; tick(1);
      ign_in = 1'b1; tick(5);
      chk("R4", outs(), 4'b0000);
      batt_ok = 1'b1; tick(5);
      chk("R4", outs(), 4'b0100);
      ign_in = 1'b0; tick(4);
      ign_in = 1'b1; tick(2);
      chk("R4", outs(), 4'b0100);
      tick(1);
      chk("R4", outs(), 4'b1100);
      ign_in = 1'b0; tick(4);
   endtask

   task automatic t_standby();
      write_pdc(1'b1);
      chk("R5", outs(), 4'b1100);
      write_pdc(1'b0);
      chk("R5", outs(), 4'b0111);
      chk("R6", {3'b000, clamp_en}, 4'b0001);
      tick(6);
      chk("R6", outs(), 4'b0111);
   endtask

   task automatic t_ign_wake();
      ign_pulse();
      chk("R7", outs(), 4'b1100);
   endtask

   task automatic t_bus();
      opt_byte = 8'h60;
      write_pdc(1'b0);
      bus_in = 1'b1; tick(6);
      chk("R8", outs(), 4'b0111);
      bus_in = 1'b0; tick(4);
      opt_byte = 8'h70;
      bus_in = 1'b1; tick(5);
      chk("R8", outs(), 4'b1100);
      bus_in = 1'b0; tick(4);
   endtask

   task automatic t_noclamp();
      opt_byte = 8'h50;
      write_pdc(1'b0);
      chk("R6", outs(), 4'b0101);
      ign_pulse();
      chk("R7", outs(), 4'b1100);
      opt_byte = 8'h70;
   endtask

   task automatic t_batt_drop();
      write_pdc(1'b0);
      batt_ok = 1'b0; tick(1);
      chk("R9", outs(), 4'b0000);
      batt_ok = 1'b1; tick(4);
      chk("R9", outs(), 4'b0100);
      ign_pulse();
      chk("R9", outs(), 4'b1100);
      batt_ok = 1'b0; tick(1);
      chk("R9", outs(), 4'b0000);
      batt_ok = 1'b1; tick(1);
   endtask

   task automatic t_regen_off();
      ign_pulse();
      chk("R2", outs(), 4'b1100);
      opt_byte = 8'h30; tick(1);
      chk("R2", outs(), 4'b0100);
      ign_pulse();
      chk("R2", outs(), 4'b0100);
      write_pdc(1'b0); tick(1);
      chk("R2", outs(), 4'b0100);
      opt_byte = 8'h70; tick(1);
   endtask

   task automatic t_level();
      ign_in = 1'b1; tick(5);
      chk("R10", outs(), 4'b1100);
      write_pdc(1'b0);
      tick(8);
      chk("R10", outs(), 4'b0111);
      ign_in = 1'b0; tick(4);
      ign_pulse();
      chk("R10", outs(), 4'b1100);
   endtask

   initial begin
      t_reset();
      t_secondary();
      t_off_wake();
      t_standby();
      t_ign_wake();
      t_bus();
      t_noclamp();
      t_batt_drop();
      t_regen_off();
      t_level();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule